// File: doc/BRIEF.md
# Frame-List Schedule Walker

This block is the traversal engine of a host controller that keeps its transfer schedule in system memory. On each frame strobe, while the controller is running, it reads one entry from a 1024-entry frame list. From there it follows a chain of links. A link can point to a queue head, which holds a horizontal link and an element link, or to a transfer descriptor, which is four words long. Every descriptor is fetched and handed to an external status-update unit. That unit returns a new control word, a two-bit outcome and an interrupt mask.

The walker writes a descriptor's control word back only when the unit changed it. It advances a queue head's element pointer only after a descriptor under it succeeds, and it descends depth-first when the new element link asks for it. A step budget stops schedules that loop. At the end of a frame the walker advances its frame number and presents the OR of all returned interrupt masks, together with an abort flag. Memory is reached through a single 32-bit port with a request/ready handshake.

Top module: `sched_walker`

## Requirements
- R1: The first access of a frame is a read at byte address {list_page, frm_num[9:0], 2'b00}. The upper address bits come from list_page and the two low bits are zero.
- R2: In any link word, bit 0 set means terminate, bit 1 set means the target is a queue head, and bit 2 set requests depth-first descent. The target address is the word with bits 3:0 cleared. A terminate link ends the frame.
- R3: A queue head is read as its horizontal link at +0 and its element link at +4. If the element link terminates, the walk continues at the horizontal link. If the element link points to a queue head, the walk continues at that queue head.
- R4: When a descriptor under a queue head succeeds (td_res = 2'b00), the descriptor's link word is written to the queue head at +4. If that link has bit 2 set, the same queue head is processed again at once. Otherwise the walk continues at the horizontal link.
- R5: When a descriptor under a queue head does not succeed (td_res = 2'b01), the queue head's element word is left unchanged and the walk continues at the horizontal link.
- R6: A descriptor reached directly by a link, rather than through a queue head, is always followed by its own link word (+0), whatever the outcome.
- R7: A descriptor is read at +0, +4, +8 and +12 (link, control, token, buffer). td_ctrl_new is written back to +4 only when it differs from the control word that was read.
- R8: Each frame has a budget of BUDGET steps (default 100). One step is taken for each non-terminate link visited and one for each descriptor taken from a queue head. When the count reaches zero, the frame ends. A descriptor that links to itself is therefore processed 99 times.
- R9: An outcome with td_res[1] set ends the frame right after any control write-back, and frm_abort is 1 for that frame.
- R10: At frame end, frm_done pulses for one cycle, frm_num increments modulo 2048, frm_mask shows the OR of all td_mask values of the frame, and frm_int is 1 exactly when frm_mask is nonzero.
- R11: A frame strobe with run low starts no memory access and sets halted. A strobe with run high clears halted and starts a frame.
- R12: mem_req, mem_we, mem_addr and mem_wdata hold steady until mem_rdy. td_req and the descriptor words hold steady until td_ack. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | Frame strobe |
| run | input | 1 | Controller running |
| list_page | input | 20 | Frame-list base, address bits 31:12 |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdy | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_rdy |
| td_req | output | 1 | Descriptor offered to the status unit |
| td_ctrl | output | 32 | Control word as read |
| td_token | output | 32 | Token word |
| td_buf | output | 32 | Buffer pointer word |
| td_ack | input | 1 | Status unit result valid |
| td_ctrl_new | input | 32 | Updated control word |
| td_res | input | 2 | 00 success, 01 not successful, 1x abort |
| td_mask | input | 2 | Interrupt reasons raised by this descriptor |
| frm_done | output | 1 | Frame finished (one cycle) |
| frm_num | output | 11 | Frame number |
| frm_mask | output | 2 | Accumulated mask of the last frame |
| frm_abort | output | 1 | Last frame was aborted |
| frm_int | output | 1 | Last frame raised an interrupt |
| halted | output | 1 | Last strobe found run low |

## Verification
A wrong internal state shows at the ports within a single frame. A mistaken link decode or a misplaced element pointer changes the number of td_ack handshakes and memory writes before frm_done, and it leaves wrong words in the memory model. A wrong budget counter changes the length of a self-linked chain from 99. A slip in the frame counter shows as a wrong entry address on the very next strobe, and wraparound of the index is seen at frame 1024.

// File: rtl/sw_pkg.sv
package sw_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ENTRY, S_CHECK, S_QH_H, S_QH_E, S_QH_DF,
    S_TD0, S_TD1, S_TD2, S_TD3, S_EXEC, S_TD_WB, S_POST, S_QH_WB, S_DONE
  } walk_st_e;

  localparam logic [1:0] RES_OK = 2'b00;

  // Decoded link word: pointer above bit 3, queue-head and terminate flags.
  typedef struct packed {
    logic [27:0] ptr;
    logic        qh;
    logic        term;
  } lnk_t;
endpackage

// File: rtl/sw_budget.sv
module sw_budget #(
  parameter int BUDGET = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic last
);
  localparam int BUD_W = $clog2(BUDGET + 1);

  logic [BUD_W-1:0] cnt_q, cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)     cnt_n = BUD_W'(BUDGET);
    else if (dec) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load || dec) cnt_q <= cnt_n;
  end

  assign last = (cnt_q == BUD_W'(1));

  // R8
  budget_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0));
endmodule

// File: rtl/sw_frame.sv
module sw_frame #(
  parameter int FRAME_W = 11,
  parameter int MASK_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              run,
  input  logic              fsm_idle,
  input  logic              end_pulse,
  input  logic [MASK_W-1:0] acc_mask,
  input  logic              acc_abort,
  output logic              start,
  output logic              frm_done,
  output logic [FRAME_W-1:0] frm_num,
  output logic [MASK_W-1:0] frm_mask,
  output logic              frm_abort,
  output logic              halted
);
  logic [FRAME_W-1:0] num_n;
  logic [MASK_W-1:0]  mask_n;
  logic               abort_n, halt_n, upd_en;

  assign start = frame_tick && run && fsm_idle;

  always_comb begin
    num_n   = frm_num;
    mask_n  = frm_mask;
    abort_n = frm_abort;
    halt_n  = halted;
    if (end_pulse) begin
      num_n   = frm_num + 1'b1;
      mask_n  = acc_mask;
      abort_n = acc_abort;
    end
    if (frame_tick && fsm_idle) halt_n = !run;
  end

  assign upd_en = end_pulse || (frame_tick && fsm_idle);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_num   <= '0;
      frm_mask  <= '0;
      frm_abort <= 1'b0;
      halted    <= 1'b0;
      frm_done  <= 1'b0;
    end else begin
      frm_done <= end_pulse;
      if (upd_en) begin
        frm_num   <= num_n;
        frm_mask  <= mask_n;
        frm_abort <= abort_n;
        halted    <= halt_n;
      end
    end
  end

  // R10
  frame_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> (frm_num == $past(frm_num) + 1'b1));
endmodule

// File: rtl/sw_fsm.sv
module sw_fsm
  import sw_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LIST_IDX_W = 10,
  parameter int MASK_W     = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [ADDR_W-LIST_IDX_W-3:0] list_page,
  input  logic [LIST_IDX_W-1:0]        frame_idx,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [31:0]                  mem_wdata,
  input  logic                         mem_rdy,
  input  logic [31:0]                  mem_rdata,
  output logic                         td_req,
  output logic [31:0]                  td_ctrl,
  output logic [31:0]                  td_token,
  output logic [31:0]                  td_buf,
  input  logic                         td_ack,
  input  logic [31:0]                  td_ctrl_new,
  input  logic [1:0]                   td_res,
  input  logic [MASK_W-1:0]            td_mask,
  output logic                         bud_load,
  output logic                         bud_dec,
  input  logic                         bud_last,
  output logic                         idle,
  output logic                         end_pulse,
  output logic [MASK_W-1:0]            acc_mask,
  output logic                         acc_abort
);
  localparam int PW = ADDR_W - 4;

  walk_st_e           st_q, st_n;
  lnk_t               link_q, link_n, qh_h_q, qh_h_n, qh_e_q, qh_e_n;
  logic [PW-1:0]      qh_addr_q, qh_addr_n, td_addr_q, td_addr_n;
  logic [31:0]        td_link_q, td_link_n, ctrl_q, ctrl_n, tok_q, tok_n;
  logic [31:0]        buf_q, buf_n, newc_q, newc_n;
  logic [1:0]         res_q, res_n;
  logic               under_q, under_n, abort_q, abort_n;
  logic [MASK_W-1:0]  mask_q, mask_n;

  function automatic lnk_t mk_lnk(input logic [31:0] w);
    mk_lnk.ptr  = w[31:4];
    mk_lnk.qh   = w[1];
    mk_lnk.term = w[0];
  endfunction

  always_comb begin
    st_n = st_q;       link_n = link_q;   qh_h_n = qh_h_q;   qh_e_n = qh_e_q;
    qh_addr_n = qh_addr_q;  td_addr_n = td_addr_q;  td_link_n = td_link_q;
    ctrl_n = ctrl_q;   tok_n = tok_q;     buf_n = buf_q;     newc_n = newc_q;
    res_n = res_q;     under_n = under_q; abort_n = abort_q; mask_n = mask_q;
    bud_load = 1'b0;   bud_dec = 1'b0;
    mem_req = 1'b0;    mem_we = 1'b0;     mem_addr = '0;     mem_wdata = '0;
    td_req = 1'b0;
    case (st_q)
      S_IDLE: if (start) st_n = S_ENTRY;
      S_ENTRY: begin
        mem_req  = 1'b1;
        mem_addr = {list_page, frame_idx, 2'b00};
        if (mem_rdy) begin
          link_n   = mk_lnk(mem_rdata);
          bud_load = 1'b1;
          mask_n   = '0;
          abort_n  = 1'b0;
          st_n     = S_CHECK;
        end
      end
      S_CHECK: begin
        if (link_q.term) st_n = S_DONE;
        else begin
          bud_dec = 1'b1;
          if (bud_last) st_n = S_DONE;
          else if (link_q.qh) begin
            qh_addr_n = link_q.ptr;
            st_n      = S_QH_H;
          end else begin
            td_addr_n = link_q.ptr;
            under_n   = 1'b0;
            st_n      = S_TD0;
          end
        end
      end
      S_QH_H: begin
        mem_req = 1'b1; mem_addr = {qh_addr_q, 4'h0};
        if (mem_rdy) begin qh_h_n = mk_lnk(mem_rdata); st_n = S_QH_E; end
      end
      S_QH_E: begin
        mem_req = 1'b1; mem_addr = {qh_addr_q, 4'h4};
        if (mem_rdy) begin qh_e_n = mk_lnk(mem_rdata); st_n = S_QH_DF; end
      end
      S_QH_DF: begin
        if (qh_e_q.term) begin
          link_n = qh_h_q; st_n = S_CHECK;
        end else if (qh_e_q.qh) begin
          link_n = qh_e_q; st_n = S_CHECK;
        end else begin
          bud_dec = 1'b1;
          if (bud_last) st_n = S_DONE;
          else begin
            td_addr_n = qh_e_q.ptr;
            under_n   = 1'b1;
            st_n      = S_TD0;
          end
        end
      end
      S_TD0: begin
        mem_req = 1'b1; mem_addr = {td_addr_q, 4'h0};
        if (mem_rdy) begin td_link_n = mem_rdata; st_n = S_TD1; end
      end
      S_TD1: begin
        mem_req = 1'b1; mem_addr = {td_addr_q, 4'h4};
        if (mem_rdy) begin ctrl_n = mem_rdata; st_n = S_TD2; end
      end
      S_TD2: begin
        mem_req = 1'b1; mem_addr = {td_addr_q, 4'h8};
        if (mem_rdy) begin tok_n = mem_rdata; st_n = S_TD3; end
      end
      S_TD3: begin
        mem_req = 1'b1; mem_addr = {td_addr_q, 4'hC};
        if (mem_rdy) begin buf_n = mem_rdata; st_n = S_EXEC; end
      end
      S_EXEC: begin
        td_req = 1'b1;
        if (td_ack) begin
          newc_n = td_ctrl_new;
          res_n  = td_res;
          mask_n = mask_q | td_mask;
          st_n   = (td_ctrl_new != ctrl_q) ? S_TD_WB : S_POST;
        end
      end
      S_TD_WB: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = {td_addr_q, 4'h4}; mem_wdata = newc_q;
        if (mem_rdy) st_n = S_POST;
      end
      S_POST: begin
        if (res_q[1]) begin
          abort_n = 1'b1; st_n = S_DONE;
        end else if (under_q) begin
          if (res_q == RES_OK) begin
            qh_e_n = mk_lnk(td_link_q); st_n = S_QH_WB;
          end else begin
            link_n = qh_h_q; st_n = S_CHECK;
          end
        end else begin
          link_n = mk_lnk(td_link_q); st_n = S_CHECK;
        end
      end
      S_QH_WB: begin
        mem_req = 1'b1; mem_we = 1'b1;
        mem_addr = {qh_addr_q, 4'h4}; mem_wdata = td_link_q;
        if (mem_rdy) begin
          if (td_link_q[2]) st_n = S_QH_DF;
          else begin link_n = qh_h_q; st_n = S_CHECK; end
        end
      end
      S_DONE: st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;   link_q <= '0;   qh_h_q <= '0;   qh_e_q <= '0;
      qh_addr_q <= '0;  td_addr_q <= '0; td_link_q <= '0;
      ctrl_q <= '0;     tok_q <= '0;    buf_q <= '0;    newc_q <= '0;
      res_q <= '0;      under_q <= 1'b0; abort_q <= 1'b0; mask_q <= '0;
    end else begin
      st_q <= st_n;     link_q <= link_n; qh_h_q <= qh_h_n; qh_e_q <= qh_e_n;
      qh_addr_q <= qh_addr_n; td_addr_q <= td_addr_n; td_link_q <= td_link_n;
      ctrl_q <= ctrl_n; tok_q <= tok_n; buf_q <= buf_n; newc_q <= newc_n;
      res_q <= res_n;   under_q <= under_n; abort_q <= abort_n; mask_q <= mask_n;
    end
  end

  assign td_ctrl   = ctrl_q;
  assign td_token  = tok_q;
  assign td_buf    = buf_q;
  assign idle      = (st_q == S_IDLE);
  assign end_pulse = (st_q == S_DONE);
  assign acc_mask  = mask_q;
  assign acc_abort = abort_q;

  // R12
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  // R12
  td_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (td_req && !td_ack) |=> (td_req && $stable(td_token) && $stable(td_ctrl)));
  // R9
  abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_abort) |-> end_pulse);
  // R1
  word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
endmodule

// File: rtl/sched_walker.sv
module sched_walker #(
  parameter int ADDR_W     = 32,
  parameter int LIST_IDX_W = 10,
  parameter int FRAME_W    = 11,
  parameter int MASK_W     = 2,
  parameter int BUDGET     = 100
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_tick,
  input  logic                         run,
  input  logic [ADDR_W-LIST_IDX_W-3:0] list_page,
  output logic                         mem_req,
  output logic                         mem_we,
  output logic [ADDR_W-1:0]            mem_addr,
  output logic [31:0]                  mem_wdata,
  input  logic                         mem_rdy,
  input  logic [31:0]                  mem_rdata,
  output logic                         td_req,
  output logic [31:0]                  td_ctrl,
  output logic [31:0]                  td_token,
  output logic [31:0]                  td_buf,
  input  logic                         td_ack,
  input  logic [31:0]                  td_ctrl_new,
  input  logic [1:0]                   td_res,
  input  logic [MASK_W-1:0]            td_mask,
  output logic                         frm_done,
  output logic [FRAME_W-1:0]           frm_num,
  output logic [MASK_W-1:0]            frm_mask,
  output logic                         frm_abort,
  output logic                         frm_int,
  output logic                         halted
);
  logic              start, bud_load, bud_dec, bud_last, fsm_idle, end_pulse, acc_abort;
  logic [MASK_W-1:0] acc_mask;

  sw_frame #(.FRAME_W(FRAME_W), .MASK_W(MASK_W)) u_frame (
    .clk, .rst_n, .frame_tick, .run, .fsm_idle, .end_pulse, .acc_mask, .acc_abort,
    .start, .frm_done, .frm_num, .frm_mask, .frm_abort, .halted);

  sw_budget #(.BUDGET(BUDGET)) u_budget (
    .clk, .rst_n, .load(bud_load), .dec(bud_dec), .last(bud_last));

  sw_fsm #(.ADDR_W(ADDR_W), .LIST_IDX_W(LIST_IDX_W), .MASK_W(MASK_W)) u_fsm (
    .clk, .rst_n, .start, .list_page, .frame_idx(frm_num[LIST_IDX_W-1:0]),
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdy, .mem_rdata,
    .td_req, .td_ctrl, .td_token, .td_buf, .td_ack, .td_ctrl_new, .td_res, .td_mask,
    .bud_load, .bud_dec, .bud_last, .idle(fsm_idle), .end_pulse, .acc_mask, .acc_abort);

  assign frm_int = |frm_mask;

  // R11
  halt_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !run && fsm_idle) |=> (halted && !mem_req));
endmodule

// File: tb/tb_sched_walker.sv
module tb_sched_walker;
  logic        clk = 1'b0, rst_n = 1'b0, frame_tick = 1'b0, run = 1'b0;
  logic [19:0] list_page = 20'h0;
  logic        mem_req, mem_we, mem_rdy, td_req, td_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, td_ctrl, td_token, td_buf, td_ctrl_new;
  logic [1:0]  td_res, td_mask, frm_mask;
  logic        frm_done, frm_abort, frm_int, halted;
  logic [10:0] frm_num;

  always #10 clk = ~clk;

  sched_walker dut (.*);

  // memory model: 2048 words, index from address bits 12:2
  logic [31:0] mem [0:2047];
  logic        ph = 1'b0, poke_en = 1'b0;
  logic [10:0] poke_idx = '0;
  logic [31:0] poke_dat = '0;
  int          wr_tot = 0, td_tot = 0, cyc = 0;
  int          nchk = 0, nfail = 0;

  always @(negedge clk) ph <= ~ph;
  assign mem_rdy   = mem_req & ph;
  assign mem_rdata = mem[mem_addr[12:2]];
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (poke_en) mem[poke_idx] <= poke_dat;
    else if (mem_req && mem_we && mem_rdy) begin
      mem[mem_addr[12:2]] <= mem_wdata;
      wr_tot <= wr_tot + 1;
    end
    if (td_req && td_ack) td_tot <= td_tot + 1;
    if (cyc > 150000) begin
      $display("FAIL watchdog expired: got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nchk + 1, nfail + 1);
      $finish;
    end
  end

  // status unit model: token[1:0] outcome, token[3:2] mask, token[31:16] xor into control
  assign td_ack      = td_req;
  assign td_res      = td_token[1:0];
  assign td_mask     = td_token[3:2];
  assign td_ctrl_new = td_ctrl ^ {16'h0, td_token[31:16]};

  function automatic logic [31:0] tk(input logic [1:0] r, input logic [1:0] m, input logic [15:0] c);
    tk = {c, 12'h0, m, r};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] byte_addr, input logic [31:0] d);
    @(negedge clk);
    poke_idx = byte_addr[12:2]; poke_dat = d; poke_en = 1'b1;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  task automatic put_td(input logic [31:0] a, input logic [31:0] l, input logic [31:0] t);
    poke(a, l); poke(a + 4, 32'h0080_0000); poke(a + 8, t); poke(a + 12, 32'hB0F0_0000 | a);
  endtask

  task automatic build;
    put_td(32'h1000, 32'h1,    tk(2'd0, 2'b01, 16'h0040)); // A
    put_td(32'h1010, 32'h1000, tk(2'd1, 2'b10, 16'h0));    // B
    put_td(32'h1020, 32'h1034, tk(2'd0, 2'b00, 16'h0));    // C depth link to D
    put_td(32'h1030, 32'h1,    tk(2'd0, 2'b00, 16'h0080)); // D
    put_td(32'h1040, 32'h1,    tk(2'd1, 2'b10, 16'h0));    // E
    put_td(32'h1050, 32'h1000, tk(2'd2, 2'b01, 16'h0001)); // F abort
    put_td(32'h1060, 32'h1060, tk(2'd1, 2'b00, 16'h0));    // L self loop
    poke(32'h1100, 32'h1);    poke(32'h1104, 32'h1020);    // QH1
    poke(32'h1110, 32'h1000); poke(32'h1114, 32'h1040);    // QH2
    poke(32'h1120, 32'h1000); poke(32'h1124, 32'h1);       // QH3
    poke(32'h1130, 32'h1);    poke(32'h1134, 32'h1122);    // QH4
  endtask

  task automatic tick_frame;
    @(negedge clk); frame_tick = 1'b1;
    @(negedge clk); frame_tick = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if (frm_done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (!ok) chk("R10 frame end", 32'h0, 32'h1);
  endtask

  // {entry link, mask, abort, descriptors handled, memory writes}
  localparam logic [50:0] VEC [0:8] = '{
    {32'h0000_0001, 2'b00, 1'b0, 8'd0,  8'd0},  // R2 terminate entry
    {32'h0000_1008, 2'b01, 1'b0, 8'd1,  8'd1},  // R2 R6 R7 bare, low bits masked
    {32'h0000_1010, 2'b11, 1'b0, 8'd2,  8'd1},  // R6 R7 chain B->A
    {32'h0000_1102, 2'b00, 1'b0, 8'd2,  8'd3},  // R4 depth-first
    {32'h0000_1112, 2'b11, 1'b0, 8'd2,  8'd1},  // R5 failure goes horizontal
    {32'h0000_1050, 2'b01, 1'b1, 8'd1,  8'd1},  // R9 abort
    {32'h0000_1122, 2'b01, 1'b0, 8'd1,  8'd1},  // R3 empty element
    {32'h0000_1132, 2'b01, 1'b0, 8'd1,  8'd1},  // R3 element is queue head
    {32'h0000_1060, 2'b00, 1'b0, 8'd99, 8'd0}   // R8 budget
  };

  task automatic run_vec(input int v, input bit check_io);
    int w0, t0; bit ok; logic [10:0] f0;
    build();
    poke({19'h0, frm_num[9:0], 2'b00}, VEC[v][50:19]);
    w0 = wr_tot; t0 = td_tot; f0 = frm_num;
    tick_frame();
    if (check_io) begin
      chk("R1 entry read", {mem_req, mem_we, mem_addr},
          {1'b1, 1'b0, list_page, f0[9:0], 2'b00});
    end
    wait_done(ok);
    chk("R10 mask", {30'h0, frm_mask}, {30'h0, VEC[v][18:17]});
    chk("R10 int", {31'h0, frm_int}, {31'h0, |VEC[v][18:17]});
    chk("R9 abort", {31'h0, frm_abort}, {31'h0, VEC[v][16]});
    chk("R3 R4 R5 R6 R8 descriptors", td_tot - t0, {24'h0, VEC[v][15:8]});
    chk("R4 R7 writes", wr_tot - w0, {24'h0, VEC[v][7:0]});
    chk("R10 frame number", {21'h0, frm_num}, {21'h0, f0 + 11'd1});
  endtask

  initial begin
    bit ok;
    repeat (3) @(negedge clk);
    // reset state, R12
    chk("R12 reset outputs", {mem_req, td_req, frm_done, frm_abort, frm_int, halted, frm_mask},
        8'h00);
    chk("R12 reset frame number", {21'h0, frm_num}, 32'h0);
    rst_n = 1'b1;
    list_page = 20'h0;
    // R11 halt: strobe with run low
    tick_frame();
    for (int i = 0; i < 6; i++) begin
      chk("R11 no fetch when halted", {31'h0, mem_req}, 32'h0);
      @(negedge clk);
    end
    chk("R11 halted set", {31'h0, halted}, 32'h1);
    chk("R11 frame number held", {21'h0, frm_num}, 32'h0);
    run = 1'b1;

    // table walk
    for (int v = 0; v < 9; v++) run_vec(v, 1'b1);
    chk("R11 halted cleared", {31'h0, halted}, 32'h0);

    // directed memory-image checks
    run_vec(3, 1'b0);
    chk("R4 element advanced to terminate", mem[32'h1104 >> 2], 32'h1);
    chk("R7 D control written", mem[32'h1034 >> 2], 32'h0080_0080);
    chk("R7 C control untouched", mem[32'h1024 >> 2], 32'h0080_0000);
    run_vec(4, 1'b0);
    chk("R5 element unchanged", mem[32'h1114 >> 2], 32'h1040);
    chk("R7 A control written", mem[32'h1004 >> 2], 32'h00800040);
    run_vec(5, 1'b0);
    chk("R9 abort write-back", mem[32'h1054 >> 2], 32'h0080_0001);
    chk("R9 A not visited", mem[32'h1004 >> 2], 32'h0080_0000);

    // R1 page bits and index wrap at 1024
    list_page = 20'h0ABC2;
    for (int i = 0; i < 1024; i++) poke(i * 4, 32'h1);
    while (frm_num != 11'd1023) begin
      tick_frame(); wait_done(ok);
      if (!ok) break;
    end
    tick_frame(); wait_done(ok);
    chk("R10 frame number past 1023", {21'h0, frm_num}, 32'd1024);
    tick_frame();
    chk("R1 index wraps", mem_addr, {20'h0ABC2, 10'h0, 2'b00});
    wait_done(ok);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule